// File: doc/BRIEF.md
# Pixel Histogram Accumulator

The block builds a live histogram of a video stream. Each accepted pixel value addresses one bin of a 256-entry, 16-bit count memory. That bin is raised by one through a read-modify-write pass. The block runs on a clock at twice the pixel rate, so each pixel period holds one read sub-cycle and one write sub-cycle. One incrementer serves every bin.

Pixels are counted only while the active-low blanking input is high. A host reads any bin at any time through a second, independent memory port. A clear request zeroes all bins between frames. Reset also starts a clear, so the block comes out of reset with every bin at zero.

Top module: `pixel_hist`

## Requirements
- R1: A pixel strobed with `pix_valid` high, `blank_n` high and no clear pending or running is registered on that edge. The addressed bin is read in the next cycle and written one higher in the cycle after.
- R2: A pixel strobed while `blank_n` is low does not change any bin.
- R3: A bin that holds 0xFFFF stays at 0xFFFF when a further pixel hits it. It never wraps to zero.
- R4: When `host_rd` is high, `host_data` shows the bin at `host_addr` after the next clock edge. When `host_rd` is low, `host_data` holds its value.
- R5: A one-cycle `clr_req` starts a sweep as soon as no update is in flight. `clr_busy` is high for 256 cycles while the sweep writes zero to every bin.
- R6: Pixels strobed while a clear is pending or `clr_busy` is high are not counted.
- R7: From reset, `host_data` is 0 and `clr_busy` is high. The reset sweep runs for exactly 256 cycles after reset is released.
- R8: A pixel is accepted only when no read sub-cycle is under way. A strobe in the cycle right after an accepted pixel is dropped.
- R9: Pixels that hit the same bin on every pixel period are each counted.
- R10: A host read of a bin in the same cycle as that bin's write returns either the old count or the new count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock at twice the pixel rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| pix_valid | input | 1 | Pixel strobe, one cycle per pixel period |
| pix_data | input | 8 | Pixel value, selects the bin |
| blank_n | input | 1 | Active-low blanking; pixels count only when high |
| clr_req | input | 1 | Request to zero all bins |
| clr_busy | output | 1 | High while the clear sweep runs |
| host_rd | input | 1 | Host read enable |
| host_addr | input | 8 | Bin the host reads |
| host_data | output | 16 | Count of the bin read, one cycle after the request |

## Verification
On every cycle, the assertions check the following:
- Read and write sub-cycles never overlap.
- Every read is followed by a write.
- The clear sweep never runs beside a pixel update.
- A blanked strobe never starts a read.
- A write never stores zero, so no count wraps.
- `host_data` holds while the host is idle.

Only the bench scenarios can show the actual bin contents. These cover counts after mixed pixel sequences, saturation after more than 65535 hits, the 256-cycle sweep length, the dropping of strobes during clears, and the old-or-new result of a colliding host read. The bench compares each of these against its own reference histogram.

// File: rtl/pixel_hist.sv
module pixel_hist #(
  parameter int PIX_W = 8,
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pix_valid,
  input  logic [PIX_W-1:0] pix_data,
  input  logic             blank_n,
  input  logic             clr_req,
  output logic             clr_busy,
  input  logic             host_rd,
  input  logic [PIX_W-1:0] host_addr,
  output logic [CNT_W-1:0] host_data
);
  localparam int BINS = 1 << PIX_W;
  localparam logic [CNT_W-1:0] CMAX = '1;

  logic [CNT_W-1:0] mem [BINS];
  logic [PIX_W-1:0] addr_q, clr_addr;
  logic             rd_v, wr_v, clr_pend, busy_q;
  logic [CNT_W-1:0] rdata;

  wire clr_go = (clr_req | clr_pend) & ~rd_v & ~wr_v & ~busy_q;
  wire acc    = pix_valid & blank_n & ~rd_v & ~busy_q & ~clr_pend & ~clr_req;
  wire [CNT_W-1:0] wdata = (rdata == CMAX) ? CMAX : rdata + 1'b1;

  assign clr_busy = busy_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q   <= '0;
      rd_v     <= 1'b0;
      wr_v     <= 1'b0;
      clr_pend <= 1'b0;
      busy_q   <= 1'b1;
      clr_addr <= '0;
    end else begin
      rd_v     <= acc;
      wr_v     <= rd_v;
      clr_pend <= (clr_pend | clr_req) & ~clr_go;
      if (acc) addr_q <= pix_data;
      if (clr_go) begin
        busy_q   <= 1'b1;
        clr_addr <= '0;
      end else if (busy_q) begin
        clr_addr <= clr_addr + 1'b1;
        if (&clr_addr) busy_q <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (busy_q)    mem[clr_addr] <= '0;
    else if (wr_v) mem[addr_q]   <= wdata;
  end

  always_ff @(posedge clk) begin
    if (rd_v) rdata <= mem[addr_q];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       host_data <= '0;
    else if (host_rd) host_data <= mem[host_addr];
  end

  assert_one_phase_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !(rd_v && wr_v));
  assert_write_after_read_R1: assert property (@(posedge clk) disable iff (!rst_n)
    rd_v |=> wr_v);
  assert_no_wrap_R3: assert property (@(posedge clk) disable iff (!rst_n)
    wr_v |-> (wdata != '0));
  assert_clear_alone_R6: assert property (@(posedge clk) disable iff (!rst_n)
    clr_busy |-> (!rd_v && !wr_v));
  assert_blank_drop_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (pix_valid && !blank_n) |=> !rd_v);
  assert_host_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !host_rd |=> $stable(host_data));
endmodule

// File: tb/pixel_hist_tb_top.sv
module pixel_hist_tb_top;
  logic clk = 0, rst_n = 0, pix_valid = 0, blank_n = 1, clr_req = 0, host_rd = 0;
  logic [7:0] pix_data = 0, host_addr = 0;
  logic clr_busy;
  logic [15:0] host_data;
  int n_chk = 0, n_fail = 0;
  int ref_cnt [256];
  int q_exp[$], q_alt[$];
  string q_tag[$];
  logic mon_pend = 0;

  always #2 clk = ~clk;

  pixel_hist dut_i (.clk(clk), .rst_n(rst_n), .pix_valid(pix_valid), .pix_data(pix_data),
    .blank_n(blank_n), .clr_req(clr_req), .clr_busy(clr_busy), .host_rd(host_rd),
    .host_addr(host_addr), .host_data(host_data));

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  always @(posedge clk) mon_pend <= host_rd;
  always @(negedge clk) if (mon_pend && q_exp.size() > 0) begin
    int e, a;
    string t;
    e = q_exp.pop_front(); a = q_alt.pop_front(); t = q_tag.pop_front();
    chk(int'(host_data) == e || int'(host_data) == a, t, host_data, e);
  end

  task automatic send_pix(input int v, input bit b, input bit counted);
    @(negedge clk); pix_valid = 1; pix_data = 8'(v); blank_n = b;
    @(negedge clk); pix_valid = 0; blank_n = 1;
    if (counted && b && ref_cnt[v] < 65535) ref_cnt[v]++;
  endtask

  task automatic host_check(input int a, input string tag);
    @(negedge clk); host_rd = 1; host_addr = 8'(a);
    q_exp.push_back(ref_cnt[a]); q_alt.push_back(ref_cnt[a]); q_tag.push_back(tag);
    @(negedge clk); host_rd = 0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    #760000;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    int n;
    logic [15:0] held;
    foreach (ref_cnt[i]) ref_cnt[i] = 0;
    idle(3);
    chk(clr_busy == 1, "R7 busy in reset", clr_busy, 1);
    chk(host_data == 0, "R7 host_data reset", host_data, 0);
    rst_n = 1;
    n = 0;
    while (clr_busy) begin @(negedge clk); n++; end
    chk(n == 256, "R7 reset sweep length", n, 256);
    host_check(0, "R5 bin0 zero"); host_check(255, "R5 bin255 zero");

    send_pix(10, 1, 1); send_pix(42, 1, 1); send_pix(33, 1, 1);
    send_pix(10, 1, 1); send_pix(73, 1, 1);
    idle(3);
    host_check(10, "R1 bin10"); host_check(42, "R1 bin42");
    host_check(33, "R1 bin33"); host_check(73, "R1 bin73");

    for (int i = 0; i < 8; i++) send_pix(200, 1, 1);
    idle(3);
    host_check(200, "R9 back-to-back bin200");

    for (int i = 0; i < 4; i++) send_pix(7, 0, 1);
    send_pix(8, 0, 1); send_pix(8, 1, 1); send_pix(8, 0, 1); send_pix(8, 1, 1);
    idle(3);
    host_check(7, "R2 blanked bin7"); host_check(8, "R2 mixed bin8");

    @(negedge clk); pix_valid = 1; pix_data = 90;
    @(negedge clk); pix_data = 91;
    @(negedge clk); pix_valid = 0;
    ref_cnt[90]++;
    idle(3);
    host_check(90, "R8 first accepted"); host_check(91, "R8 second dropped");

    @(negedge clk); pix_valid = 1; pix_data = 5;
    @(negedge clk); pix_valid = 0;
    @(negedge clk); host_rd = 1; host_addr = 5;
    q_exp.push_back(ref_cnt[5]); q_alt.push_back(ref_cnt[5] + 1); q_tag.push_back("R10 collide");
    @(negedge clk); host_rd = 0;
    ref_cnt[5]++;
    idle(3);
    host_check(5, "R10 bin5 after");

    host_check(42, "R4 setup");
    idle(1);
    held = host_data;
    send_pix(42, 1, 1); idle(4);
    chk(host_data == held, "R4 hold while idle", host_data, held);

    @(negedge clk); clr_req = 1; pix_valid = 1; pix_data = 60;
    @(negedge clk); clr_req = 0; pix_valid = 0;
    chk(clr_busy == 1, "R5 busy after request", clr_busy, 1);
    send_pix(61, 1, 0); send_pix(62, 1, 0);
    while (clr_busy) @(negedge clk);
    foreach (ref_cnt[i]) ref_cnt[i] = 0;
    host_check(10, "R5 bin10 cleared"); host_check(200, "R5 bin200 cleared");
    host_check(60, "R6 strobe at request"); host_check(61, "R6 strobe in sweep");

    for (int i = 0; i < 65537; i++) send_pix(255, 1, 1);
    idle(3);
    host_check(255, "R3 saturated"); host_check(254, "R3 neighbour");
    idle(3);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule